// File: doc/BRIEF.md
# Keyboard Scancode Handshake Buffer

This block connects a keyboard-scanning controller to one input port of a CPU. The scanner reports every change of key state, whether a key goes down or comes up, as a single scancode with a one-cycle valid pulse. The buffer keeps these codes in a small first-in first-out store. While codes are waiting, it raises a ready flag that the CPU sees as one bit of a port input.

When the CPU reads the scancode port, it gets the oldest code. The same read drops the ready flag and sends a one-cycle acknowledge back to the scanner, so the scanner knows the code was taken. If codes are still waiting after the read, the flag returns one clock later. A code that arrives while every slot is taken is discarded, and a sticky overflow flag records the loss until the next reset.

The depth (nine by default) and the code width are parameters.

Top module: `kbd_scan_buffer`

## Requirements
- R1: Reset (rst_n low) leaves the queue empty, with key_ready, key_ack and ovf_flag all 0 and rd_data equal to 0.
- R2: An event sampled at clock edge k into an empty queue leaves key_ready low after edge k and raises it after edge k+1, provided no read occurs at edge k+1.
- R3: rd_data always shows the oldest stored code, and shows 0 when the queue is empty. Codes are returned in arrival order.
- R4: A read sampled at an edge forces key_ready to 0 after that edge. After the following edge without a read, key_ready is 1 if any code is still stored.
- R5: key_ack is high for the one cycle after each read edge that consumed a code. A read of an empty queue consumes nothing and gives no acknowledge.
- R6: At most DEPTH codes (9) are held. An event that arrives when DEPTH codes are stored and no read happens at the same edge is dropped, and the stored codes are left unchanged. The drop sets ovf_flag, which stays 1 until reset.
- R7: An event and a read at the same edge on a full queue are both performed. The new code is stored, and ovf_flag is not set.
- R8: Every code value from 0x00 to 0xFF passes through unchanged. Key-down and key-up codes are treated alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Scanner event strobe, one code per cycle |
| ev_code | input | CODE_W (8) | Scancode that goes with ev_valid |
| rd_stb | input | 1 | CPU read of the scancode port, one cycle per read |
| rd_data | output | CODE_W (8) | Oldest stored code, 0 when empty |
| key_ready | output | 1 | High while a code is waiting for the CPU |
| key_ack | output | 1 | One-cycle acknowledge to the scanner after a consuming read |
| ovf_flag | output | 1 | Sticky flag: an event was dropped |

## Verification
The bench aims at the full boundary. It checks that the tenth event is dropped without corrupting the nine stored codes. A design with an off-by-one count would either keep the extra code or overwrite the oldest one. It also checks a simultaneous read and event on a full queue, which a naive full test would wrongly drop and flag. It times the ready flag across a read with codes still queued. A design that left the flag high straight through the read would never show the CPU a fresh strobe. Empty-queue reads must produce neither an acknowledge nor a pointer movement. If they did, later codes would come out of order or as stale data.

// File: rtl/kbq_pkg.sv
package kbq_pkg;

  // Next slot index in a ring of the given depth.
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle with optional insert and remove.
  function automatic int unsigned occ_next(input int unsigned occ, input bit ins, input bit rem);
    return occ + (ins ? 1 : 0) - (rem ? 1 : 0);
  endfunction

endpackage

// File: rtl/kbq_store.sv
module kbq_store
  import kbq_pkg::*;
#(
  parameter int DEPTH  = 9,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] head,
  output logic              has_data,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [CNT_W-1:0]  occ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_idx == PTR_W'(i)) slot[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_idx <= PTR_W'(ring_step(int'(wr_idx), DEPTH));
      if (pop)  rd_idx <= PTR_W'(ring_step(int'(rd_idx), DEPTH));
      occ <= CNT_W'(occ_next(int'(occ), push, pop));
    end
  end

  assign has_data = (occ != '0);
  assign full     = (occ == CNT_W'(DEPTH));
  assign head     = has_data ? slot[rd_idx] : '0;

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  assert_no_write_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && !has_data));
endmodule

// File: rtl/kbq_ctl.sv
module kbq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_valid,
  input  logic rd_stb,
  input  logic has_data,
  input  logic full,
  output logic push_ok,
  output logic pop_ok,
  output logic ready,
  output logic ack,
  output logic ovf
);
  logic drop_ev;

  assign pop_ok  = rd_stb && has_data;
  assign push_ok = ev_valid && (!full || pop_ok);
  assign drop_ev = ev_valid && !push_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      ack   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      ready <= rd_stb ? 1'b0 : has_data;
      ack   <= pop_ok;
      if (drop_ev) ovf <= 1'b1;
    end
  end

  assert_read_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !ready);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_ready_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> has_data);
  assert_drop_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && full && rd_stb) |=> $stable(ovf));
endmodule

// File: rtl/kbd_scan_buffer.sv
module kbd_scan_buffer #(
  parameter int DEPTH  = 9,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              rd_stb,
  output logic [CODE_W-1:0] rd_data,
  output logic              key_ready,
  output logic              key_ack,
  output logic              ovf_flag
);
  logic push_ok, pop_ok, has_data, full;

  kbq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .rd_stb(rd_stb),
    .has_data(has_data), .full(full), .push_ok(push_ok), .pop_ok(pop_ok),
    .ready(key_ready), .ack(key_ack), .ovf(ovf_flag)
  );

  kbq_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .din(ev_code),
    .head(rd_data), .has_data(has_data), .full(full)
  );

  assert_ack_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_ack |-> $past(rd_stb));
  assert_empty_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data) |-> (rd_data == '0));
endmodule

// File: tb/kbd_scan_buffer_test.sv
module kbd_scan_buffer_test;
  localparam int DEPTH = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [7:0] ev_code = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       key_ready, key_ack, ovf_flag;

  int vectors = 0;
  int fails = 0;

  logic [7:0] mq [16];
  int         mcnt = 0;
  bit         mready = 0, mack = 0, movf = 0;

  always #2 clk = ~clk;

  kbd_scan_buffer #(.DEPTH(DEPTH), .CODE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .rd_stb(rd_stb), .rd_data(rd_data), .key_ready(key_ready),
    .key_ack(key_ack), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at the next negedge.
  task automatic cyc(input bit ev, input logic [7:0] code, input bit rd);
    bit pop, take;
    ev_valid = ev; ev_code = code; rd_stb = rd;
    #0;
    check("R3", "rd_data", rd_data, (mcnt != 0) ? mq[0] : 8'h00);
    pop  = rd && (mcnt != 0);
    take = ev && (mcnt < DEPTH || pop);
    mready = rd ? 1'b0 : (mcnt != 0);
    mack = pop;
    if (ev && !take) movf = 1'b1;
    if (pop) begin
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (take) begin
      mq[mcnt] = code;
      mcnt++;
    end
    @(posedge clk);
    @(negedge clk);
    check(rd ? "R4" : "R2", "key_ready", key_ready, mready);
    check("R5", "key_ack", key_ack, mack);
    check("R6", "ovf_flag", ovf_flag, movf);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_valid = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0; mready = 0; mack = 0; movf = 0;
    check("R1", "key_ready", key_ready, 0);
    check("R1", "key_ack", key_ack, 0);
    check("R1", "ovf_flag", ovf_flag, 0);
    check("R1", "rd_data", rd_data, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit [15:0] lf;
    @(negedge clk);
    do_reset();

    // R2: ready timing after a single event
    cyc(1, 8'h00, 0);
    check("R2", "ready right after event", key_ready, 0);
    cyc(0, 8'h00, 0);
    check("R2", "ready one edge later", key_ready, 1);
    cyc(0, 8'h00, 1);
    check("R5", "ack after read", key_ack, 1);
    cyc(0, 8'h00, 0);
    check("R5", "ack single cycle", key_ack, 0);

    // R5: read of empty queue
    cyc(0, 8'h00, 1);
    check("R5", "no ack on empty read", key_ack, 0);

    // R6: fill past capacity, then drain in order (R3)
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 8'h10 + 8'(i), 0);
    check("R6", "ovf after drop", ovf_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R3", "order", rd_data, 8'h10 + i);
      cyc(0, 8'h00, 1);
      cyc(0, 8'h00, 0);
      check("R4", "ready returns", key_ready, (i < DEPTH - 1) ? 1 : 0);
    end
    check("R6", "ovf sticky", ovf_flag, 1);

    // R7: push and pop together on a full queue
    do_reset();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'h40 + 8'(i), 0);
    cyc(1, 8'hA5, 1);
    check("R7", "no ovf on simultaneous", ovf_flag, 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1);
    check("R7", "queue empty after draining", key_ready, 0);

    // R8: every code value through the queue
    for (int c = 0; c < 256; c++) begin
      cyc(1, 8'(c), 0);
      cyc(0, 8'h00, 0);
      check("R8", "code passthrough", rd_data, c);
      cyc(0, 8'h00, 1);
    end

    // mixed traffic
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[15:8], lf[3] & lf[5]);
    end

    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule